// File: doc/BRIEF.md
# Power-up reset sequencing timer

This block keeps a processor core in reset after the supply comes up and lets it go only when two start-up delays have elapsed in turn. The first delay is a power-up wait counted in ticks of a slow internal RC time base; a configuration bit can bypass it. The second delay lets a crystal or resonator settle: it counts cycles of the oscillator input, and it runs only when the selected clock mode uses a crystal.

A power-on pulse restarts the sequence, and is the only thing that does. A fall in the supply is not seen by this block. An active-low master-clear input forces the core reset while it is low. It never restarts the timers. A wake event from sleep reruns only the oscillator settle delay. During that delay the block raises a stall output, not the core reset. Status outputs show which stage is running and which stages have completed.

All state is clocked by the oscillator-side clock. The RC time base and the oscillator input arrive as single-cycle tick enables.

Top module: `pwrup_seq`

## Requirements
- R1: While `por_pulse` is high at a clock edge, the next outputs are `core_rst`=1, `stall`=0, both busy flags 0 and both done flags 0. This restarts the block from any state.
- R2: With `pud_en`=1, the first edge after `por_pulse` falls enters the power-up stage (`pud_busy`=1, `core_rst`=1). The stage ends on the edge that samples the PUD_TICKS-th `rc_tick`, and `pud_done` rises on that edge.
- R3: With `pud_en`=0, the power-up stage is skipped and `pud_done` stays 0. The first edge after `por_pulse` falls enters the oscillator stage, or enters run when the mode is RC.
- R4: In the crystal modes (`osc_mode` 2'b00 low-power, 2'b01 standard, 2'b10 high-speed), the oscillator stage follows the power-up stage with `ost_busy`=1 and `core_rst`=1. It ends on the edge that samples the OST_CYCLES-th `osc_tick`. On that edge `ost_done` rises and `core_rst` falls.
- R5: In RC mode (`osc_mode`=2'b11), the oscillator stage never runs. `core_rst` falls on the edge that ends the power-up stage, and `ost_done` stays 0.
- R6: Each stage counts only its own tick. `osc_tick` has no effect during the power-up stage, and `rc_tick` has no effect during the oscillator stage.
- R7: A `wake_evt` in run, in a crystal mode, starts an oscillator-only delay. During it `stall`=1, `ost_busy`=1 and `core_rst` stays 0, and the delay lasts OST_CYCLES `osc_tick`s. A `wake_evt` in RC mode, or during start-up, has no effect.
- R8: A low `mclr_n` sets `core_rst` on the next edge and leaves the stage counters running. Once both stages are over, releasing `mclr_n` clears `core_rst` on the next edge and starts no stage.
- R9: A new power-on pulse in the middle of a stage clears both counters. The sequence then starts again with a full power-up stage.
- R10: `pud_done` and `ost_done` stay set until the next power-on pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-side clock |
| por_pulse | input | 1 | Power-on pulse, active high, synchronous |
| mclr_n | input | 1 | External master-clear, active low |
| wake_evt | input | 1 | Wake-from-sleep event, single cycle |
| rc_tick | input | 1 | Internal RC time-base tick enable |
| osc_tick | input | 1 | Oscillator input cycle tick enable |
| pud_en | input | 1 | Configuration: 1 enables the power-up delay |
| osc_mode | input | 2 | Clock mode: 00 low-power, 01 standard, 10 high-speed crystal, 11 RC |
| core_rst | output | 1 | Core reset, active high |
| stall | output | 1 | Core stall during the wake settle delay |
| pud_busy | output | 1 | Power-up stage running |
| ost_busy | output | 1 | Oscillator stage running (start-up or wake) |
| pud_done | output | 1 | Power-up stage has completed |
| ost_done | output | 1 | Oscillator stage has completed |

## Verification
The bench checks the tick just before each stage expires and then the expiring tick. A counter that is off by one would release the core a cycle early or late. It sends the foreign tick into each stage, which catches a stage that counts the wrong time base. A second power-on pulse arrives halfway through the power-up stage, so a counter that keeps its old value would end that stage too soon. The bench also covers wake in crystal and in RC mode, the configuration bypass, and master-clear held low both during a stage and after start-up. These catch a design that resets the core on wake, runs the settle delay in RC mode, or reruns the timers when master-clear is released.

// File: rtl/pwrup_seq_pkg.sv
package pwrup_seq_pkg;

    typedef enum logic [2:0] {
        ST_HOLD    = 3'd0,
        ST_PWRDLY  = 3'd1,
        ST_OSCDLY  = 3'd2,
        ST_RUN     = 3'd3,
        ST_WAKEDLY = 3'd4
    } seq_state_e;

    localparam logic [1:0] OSC_LP = 2'b00;
    localparam logic [1:0] OSC_XT = 2'b01;
    localparam logic [1:0] OSC_HS = 2'b10;
    localparam logic [1:0] OSC_RC = 2'b11;

    typedef struct packed {
        seq_state_e state;
        logic       rst;
        logic       stall;
        logic       pwr_done;
        logic       osc_done;
    } seq_regs_t;

    // Crystal and resonator modes need the settle delay; RC does not.
    function automatic logic needs_settle(input logic [1:0] mode);
        return (mode == OSC_LP) || (mode == OSC_XT) || (mode == OSC_HS);
    endfunction

endpackage

// File: rtl/seq_tick_cnt.sv
module seq_tick_cnt #(
    parameter int LIMIT = 1024
) (
    input  logic clk,
    input  logic clr,
    input  logic tick,
    output logic expire
);
    localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        expire = !clr && tick && (cnt_q == LAST);
        cnt_d  = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (tick) begin
            cnt_d = expire ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        cnt_q <= cnt_d;
    end

    // R6: the count moves only on a tick enable
    p_count_needs_tick_r6: assert property (@(posedge clk) disable iff (clr)
        !tick |=> (cnt_q == $past(cnt_q)));

    // R9: a clear leaves the counter at zero
    p_clear_zero_r9: assert property (@(posedge clk) disable iff (1'b0)
        clr |=> (cnt_q == '0));

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
    import pwrup_seq_pkg::*;
(
    input  logic       clk,
    input  logic       por_pulse,
    input  logic       mclr_n,
    input  logic       wake_evt,
    input  logic       pud_en,
    input  logic [1:0] osc_mode,
    input  logic       pwr_expire,
    input  logic       osc_expire,
    output seq_state_e state,
    output logic       core_rst,
    output logic       stall,
    output logic       pwr_done,
    output logic       osc_done
);
    seq_regs_t cur_q, nxt_d;
    logic      settle;

    always_comb begin
        settle = needs_settle(osc_mode);
        nxt_d  = cur_q;

        case (cur_q.state)
            ST_HOLD: begin
                if (pud_en)      nxt_d.state = ST_PWRDLY;
                else if (settle) nxt_d.state = ST_OSCDLY;
                else             nxt_d.state = ST_RUN;
            end
            ST_PWRDLY: begin
                if (pwr_expire) begin
                    nxt_d.pwr_done = 1'b1;
                    nxt_d.state    = settle ? ST_OSCDLY : ST_RUN;
                end
            end
            ST_OSCDLY: begin
                if (osc_expire) begin
                    nxt_d.osc_done = 1'b1;
                    nxt_d.state    = ST_RUN;
                end
            end
            ST_RUN: begin
                if (wake_evt && settle) nxt_d.state = ST_WAKEDLY;
            end
            ST_WAKEDLY: begin
                if (osc_expire) nxt_d.state = ST_RUN;
            end
            default: nxt_d.state = ST_HOLD;
        endcase

        if (por_pulse) begin
            nxt_d.state    = ST_HOLD;
            nxt_d.pwr_done = 1'b0;
            nxt_d.osc_done = 1'b0;
        end

        nxt_d.rst   = por_pulse || !mclr_n ||
                      (nxt_d.state == ST_HOLD) ||
                      (nxt_d.state == ST_PWRDLY) ||
                      (nxt_d.state == ST_OSCDLY);
        nxt_d.stall = (nxt_d.state == ST_WAKEDLY);
    end

    always_ff @(posedge clk) begin
        cur_q <= nxt_d;
    end

    assign state    = cur_q.state;
    assign core_rst = cur_q.rst;
    assign stall    = cur_q.stall;
    assign pwr_done = cur_q.pwr_done;
    assign osc_done = cur_q.osc_done;

    // R2: the core is held while the power-up stage runs
    p_hold_in_pwrdly_r2: assert property (@(posedge clk) disable iff (por_pulse)
        (cur_q.state == ST_PWRDLY) |-> cur_q.rst);

    // R3: a bypassed power-up stage is never entered
    p_bypass_pwrdly_r3: assert property (@(posedge clk) disable iff (por_pulse)
        (cur_q.state == ST_HOLD && !pud_en) |=> (cur_q.state != ST_PWRDLY));

    // R5: RC mode goes from power-up straight to run
    p_rc_skip_r5: assert property (@(posedge clk) disable iff (por_pulse)
        (cur_q.state == ST_PWRDLY && pwr_expire && osc_mode == OSC_RC)
        |=> (cur_q.state == ST_RUN && !cur_q.osc_done));

    // R7: a wake delay never falls back into the power-up stage
    p_wake_no_pwr_r7: assert property (@(posedge clk) disable iff (por_pulse)
        (cur_q.state == ST_WAKEDLY) |=> (cur_q.state != ST_PWRDLY));

    // R8: master-clear low forces reset on the next edge
    p_mclr_forces_r8: assert property (@(posedge clk) disable iff (por_pulse)
        !mclr_n |=> cur_q.rst);

    // R8: released master-clear in run clears reset on the next edge
    p_mclr_release_r8: assert property (@(posedge clk) disable iff (por_pulse)
        (cur_q.state == ST_RUN && mclr_n) |=> !cur_q.rst);

    // R10: done flags hold until a power-on pulse
    p_done_sticky_r10: assert property (@(posedge clk) disable iff (por_pulse)
        (cur_q.pwr_done && cur_q.osc_done) |=> (cur_q.pwr_done && cur_q.osc_done));

endmodule

// File: rtl/pwrup_seq.sv
module pwrup_seq
    import pwrup_seq_pkg::*;
#(
    parameter int PUD_TICKS  = 72,
    parameter int OST_CYCLES = 1024
) (
    input  logic       clk,
    input  logic       por_pulse,
    input  logic       mclr_n,
    input  logic       wake_evt,
    input  logic       rc_tick,
    input  logic       osc_tick,
    input  logic       pud_en,
    input  logic [1:0] osc_mode,
    output logic       core_rst,
    output logic       stall,
    output logic       pud_busy,
    output logic       ost_busy,
    output logic       pud_done,
    output logic       ost_done
);
    seq_state_e state;
    logic       pwr_expire, osc_expire;
    logic       pwr_clr, osc_clr;

    assign pud_busy = (state == ST_PWRDLY);
    assign ost_busy = (state == ST_OSCDLY) || (state == ST_WAKEDLY);
    assign pwr_clr  = por_pulse || !pud_busy;
    assign osc_clr  = por_pulse || !ost_busy;

    seq_tick_cnt #(.LIMIT(PUD_TICKS)) u_pwr_cnt (
        .clk    (clk),
        .clr    (pwr_clr),
        .tick   (rc_tick),
        .expire (pwr_expire)
    );

    seq_tick_cnt #(.LIMIT(OST_CYCLES)) u_osc_cnt (
        .clk    (clk),
        .clr    (osc_clr),
        .tick   (osc_tick),
        .expire (osc_expire)
    );

    seq_ctrl u_ctrl (
        .clk        (clk),
        .por_pulse  (por_pulse),
        .mclr_n     (mclr_n),
        .wake_evt   (wake_evt),
        .pud_en     (pud_en),
        .osc_mode   (osc_mode),
        .pwr_expire (pwr_expire),
        .osc_expire (osc_expire),
        .state      (state),
        .core_rst   (core_rst),
        .stall      (stall),
        .pwr_done   (pud_done),
        .osc_done   (ost_done)
    );

    // R6: at most one stage counts at a time
    p_one_stage_r6: assert property (@(posedge clk) disable iff (por_pulse)
        !(pud_busy && ost_busy));

    // R7: stall only appears inside an oscillator delay after start-up
    p_stall_in_osc_r7: assert property (@(posedge clk) disable iff (por_pulse)
        stall |-> (ost_busy && pud_done | ost_busy && !pud_busy));

endmodule

// File: tb/test_pwrup_seq.sv
module test_pwrup_seq;
    localparam int P = 6;
    localparam int O = 10;

    logic clk = 1'b0;
    logic por_pulse = 1'b1, mclr_n = 1'b1, wake_evt = 1'b0;
    logic rc_tick = 1'b0, osc_tick = 1'b0, pud_en = 1'b1;
    logic [1:0] osc_mode = 2'b01;
    logic core_rst, stall, pud_busy, ost_busy, pud_done, ost_done;
    logic [5:0] outv;

    typedef struct { string req; logic [5:0] v; } exp_t;
    exp_t exp_q[$];
    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    pwrup_seq #(.PUD_TICKS(P), .OST_CYCLES(O)) i_pwrup_seq (
        .clk(clk), .por_pulse(por_pulse), .mclr_n(mclr_n), .wake_evt(wake_evt),
        .rc_tick(rc_tick), .osc_tick(osc_tick), .pud_en(pud_en), .osc_mode(osc_mode),
        .core_rst(core_rst), .stall(stall), .pud_busy(pud_busy), .ost_busy(ost_busy),
        .pud_done(pud_done), .ost_done(ost_done)
    );

    // bit order: {core_rst, stall, pud_busy, ost_busy, pud_done, ost_done}
    assign outv = {core_rst, stall, pud_busy, ost_busy, pud_done, ost_done};

    // Monitor: compare queued expectations just after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            while (exp_q.size() > 0) begin
                exp_t it;
                it = exp_q.pop_front();
                checks++;
                if (outv !== it.v) begin
                    errors++;
                    $display("FAIL %s: got %b expected %b", it.req, outv, it.v);
                end
            end
        end
    end

    // Driver: set inputs for one edge, optionally queue the expected outputs after it
    task automatic cyc(input logic rt, input logic ot, input logic wk,
                       input string req = "", input logic [5:0] ev = '0, input bit chk = 0);
        rc_tick  = rt;
        osc_tick = ot;
        wake_evt = wk;
        if (chk) exp_q.push_back('{req, ev});
        @(negedge clk);
    endtask

    task automatic power_on(input string req);
        por_pulse = 1'b1;
        cyc(0, 0, 0, req, 6'b100000, 1);
        por_pulse = 1'b0;
    endtask

    initial begin
        // R1 reset state, standard crystal, delay enabled
        pud_en = 1'b1; osc_mode = 2'b01;
        power_on("R1");
        cyc(0, 0, 0, "R2", 6'b101000, 1);
        for (int i = 0; i < P - 1; i++) cyc(1, 1, 0);
        cyc(0, 1, 1, "R6", 6'b101000, 1);           // osc tick and wake ignored in power-up
        cyc(1, 0, 0, "R2", 6'b100110, 1);           // last rc tick ends stage
        for (int i = 0; i < 4; i++) cyc(1, 1, 0);
        mclr_n = 1'b0;
        cyc(0, 1, 0, "R8", 6'b100110, 1);
        cyc(0, 1, 0);
        mclr_n = 1'b1;
        for (int i = 0; i < O - 7; i++) cyc(1, 1, 0);
        cyc(1, 0, 0, "R6", 6'b100110, 1);           // rc tick ignored in oscillator stage
        cyc(0, 1, 0, "R4", 6'b000011, 1);           // O-th osc tick releases
        cyc(0, 0, 0, "R10", 6'b000011, 1);
        // R8 master-clear after start-up
        mclr_n = 1'b0;
        cyc(0, 0, 0, "R8", 6'b100011, 1);
        mclr_n = 1'b1;
        cyc(0, 0, 0, "R8", 6'b000011, 1);
        cyc(0, 0, 0, "R8", 6'b000011, 1);
        // R7 wake in crystal mode
        cyc(0, 0, 1, "R7", 6'b010111, 1);
        for (int i = 0; i < O - 1; i++) cyc(1, 1, 0);
        cyc(0, 0, 0, "R7", 6'b010111, 1);
        cyc(0, 1, 0, "R7", 6'b000011, 1);
        // R7 wake in RC mode ignored
        osc_mode = 2'b11;
        cyc(0, 0, 1, "R7", 6'b000011, 1);
        cyc(0, 1, 0, "R7", 6'b000011, 1);
        // R5 RC mode start-up
        power_on("R10");
        cyc(0, 0, 0, "R5", 6'b101000, 1);
        for (int i = 0; i < P - 1; i++) cyc(1, 0, 0);
        cyc(1, 0, 0, "R5", 6'b000010, 1);
        // R3 bypass with high-speed crystal
        pud_en = 1'b0; osc_mode = 2'b10;
        power_on("R1");
        cyc(0, 0, 0, "R3", 6'b100100, 1);
        for (int i = 0; i < O - 1; i++) cyc(0, 1, 0);
        cyc(0, 1, 0, "R3", 6'b000001, 1);
        // R3 bypass with RC mode
        osc_mode = 2'b11;
        power_on("R1");
        cyc(0, 0, 0, "R3", 6'b000000, 1);
        // R9 restart mid power-up, low-power crystal
        pud_en = 1'b1; osc_mode = 2'b00;
        power_on("R1");
        cyc(0, 0, 0);
        for (int i = 0; i < 3; i++) cyc(1, 0, 0);
        power_on("R9");
        cyc(0, 0, 0, "R9", 6'b101000, 1);
        for (int i = 0; i < P - 1; i++) cyc(1, 0, 0);
        cyc(0, 0, 0, "R9", 6'b101000, 1);
        cyc(1, 0, 0, "R9", 6'b100110, 1);
        for (int i = 0; i < O - 1; i++) cyc(0, 1, 0);
        cyc(0, 1, 0, "R4", 6'b000011, 1);
        cyc(0, 0, 0);
        cyc(0, 0, 0);
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule